// File: doc/BRIEF.md
# Expansion Bus Cycle Sequencer

This block runs the bus cycles of an 8-bit expansion channel that has a 20-bit address and a separate 8-bit data path. It takes transfer requests from a processor port and a DMA port. It also raises refresh requests of its own from a free-running interval timer. One cycle runs at a time. The sequencer counts its clocks, drives the one command strobe that matches the cycle, and lets a slow device stretch the cycle with a ready input.

The cycle length depends on where the cycle comes from. A processor memory access takes four clocks. A processor I/O access, a DMA transfer and a refresh each take five. A refresh drives an 8-bit row address taken from an internal counter. A channel-check error input sets a sticky interrupt request, and the request stays set until it is acknowledged.

Top module: `ebs_sequencer`

## Requirements
- R1: With ready held high, a processor memory cycle (kind 0 = memory read, 1 = memory write) lasts 4 clocks. The command strobe is high in clocks 2 through 4 (3 clocks), and the address stays stable while the strobe is high.
- R2: With ready held high, a processor I/O cycle (kind 2 = I/O read, 3 = I/O write) lasts 5 clocks, and the strobe is high for 4 clocks. I/O cycles drive only address bits 8..0, and bits 19..9 are zero.
- R3: A DMA cycle lasts 5 clocks, with the strobe high for 4 clocks, and dma_ack is high in its first clock. The kind uses the same encoding as the processor port.
- R4: A refresh becomes pending every 72 clocks. A refresh cycle lasts 5 clocks and asserts only the memory read strobe, for 4 clocks. It drives the row counter on address bits 7..0, and the counter advances by one after each refresh.
- R5: Ready is sampled on each rising edge in the next-to-last clock of a cycle. While ready is low, the cycle stays in that clock, so each low sample adds one strobe clock.
- R6: A refresh that becomes due during a cycle starts in the clock right after that cycle ends. When several requests are present at a cycle boundary, refresh goes first, then DMA, then the processor. The winner's ack is high in clock 1.
- R7: At most one of the four command strobes is high at any time.
- R8: chan_chk high on a clock edge sets nmi_req. nmi_ack clears it, and set wins if both are high together.
- R9: In processor write cycles, bus_doe is high while the strobe is high, with the write data on bus_dout. DMA and read cycles never drive data. Processor read data on bus_din is captured into rd_data at the end of the cycle's last clock.
- R10: A synchronous active-high reset leaves all strobes, acks, bus_doe, refresh_cyc, nmi_req and rd_data low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor transfer request, held until cpu_ack |
| cpu_kind | input | 2 | Processor cycle kind |
| cpu_addr | input | 20 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_ack | output | 1 | First clock of a processor cycle |
| dma_req | input | 1 | DMA transfer request, held until dma_ack |
| dma_kind | input | 2 | DMA cycle kind |
| dma_addr | input | 20 | DMA address |
| dma_ack | output | 1 | First clock of a DMA cycle |
| bus_ready | input | 1 | Device ready, low inserts wait states |
| bus_din | input | 8 | Data from the channel |
| chan_chk | input | 1 | Channel error report |
| nmi_ack | input | 1 | Clears the interrupt request |
| bus_addr | output | 20 | Channel address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| bus_dout | output | 8 | Data to the channel |
| bus_doe | output | 1 | Data drive enable |
| rd_data | output | 8 | Last processor read data |
| refresh_cyc | output | 1 | A refresh cycle is running |
| nmi_req | output | 1 | Latched non-maskable interrupt request |

## Verification
The bench builds the block with its default parameters: 4 and 5 clock cycle lengths, a 72-clock refresh interval, an 8-bit row counter and 9 I/O address bits. At a 72-clock interval a refresh comes due several times within a few hundred clocks. This makes the case where a refresh waits behind a long ready-stretched I/O cycle easy to reach. It also lets the test present simultaneous DMA and processor requests while a refresh is still running. A full 256-step wrap of the row counter is left to the clock-by-clock model rather than to a directed check.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  // bit 1 of the kind selects I/O space, bit 0 selects write
  typedef enum logic [1:0] {
    K_MRD  = 2'd0,
    K_MWR  = 2'd1,
    K_IORD = 2'd2,
    K_IOWR = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    O_NONE = 2'd0,
    O_CPU  = 2'd1,
    O_DMA  = 2'd2,
    O_REF  = 2'd3
  } owner_t;
endpackage

// File: rtl/ebs_refresh_timer.sv
module ebs_refresh_timer #(
  parameter int PERIOD = 72
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pend
);
  localparam int TW = $clog2(PERIOD);
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] cnt;
  logic          due;

  assign due = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= due ? '0 : cnt + 1'b1;
      // a new expiry wins over a clear in the same clock
      if (due)       pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ebs_arbiter.sv
module ebs_arbiter
  import ebs_pkg::*;
(
  input  logic   ref_pend,
  input  logic   dma_req,
  input  logic   cpu_req,
  output owner_t grant
);
  always_comb begin
    if (ref_pend)     grant = O_REF;
    else if (dma_req) grant = O_DMA;
    else if (cpu_req) grant = O_CPU;
    else              grant = O_NONE;
  end
endmodule

// File: rtl/ebs_nmi_latch.sv
module ebs_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic chk,
  input  logic ack,
  output logic nmi
);
  always_ff @(posedge clk) begin
    if (rst)      nmi <= 1'b0;
    else if (chk) nmi <= 1'b1;
    else if (ack) nmi <= 1'b0;
  end
endmodule

// File: rtl/ebs_sequencer.sv
module ebs_sequencer
  import ebs_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 8,
  parameter int IO_BITS    = 9,
  parameter int ROW_BITS   = 8,
  parameter int MEM_CLKS   = 4,
  parameter int IO_CLKS    = 5,
  parameter int DMA_CLKS   = 5,
  parameter int REF_CLKS   = 5,
  parameter int REF_PERIOD = 72
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_req,
  input  logic [1:0]    cpu_kind,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ack,
  input  logic          dma_req,
  input  logic [1:0]    dma_kind,
  input  logic [AW-1:0] dma_addr,
  output logic          dma_ack,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_din,
  input  logic          chan_chk,
  input  logic          nmi_ack,
  output logic [AW-1:0] bus_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic [DW-1:0] rd_data,
  output logic          refresh_cyc,
  output logic          nmi_req
);
  localparam int MAX_A = (MEM_CLKS > IO_CLKS) ? MEM_CLKS : IO_CLKS;
  localparam int MAX_B = (DMA_CLKS > REF_CLKS) ? DMA_CLKS : REF_CLKS;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PW    = $clog2(MAXC + 1);
  localparam logic [PW-1:0] MEM_L = PW'(MEM_CLKS);
  localparam logic [PW-1:0] IO_L  = PW'(IO_CLKS);
  localparam logic [PW-1:0] DMA_L = PW'(DMA_CLKS);
  localparam logic [PW-1:0] REF_L = PW'(REF_CLKS);

  function automatic logic [AW-1:0] shape_addr(kind_t k, logic [AW-1:0] a);
    if (k[1]) return {{(AW-IO_BITS){1'b0}}, a[IO_BITS-1:0]};
    return a;
  endfunction

  // cycle state
  logic                busy;
  logic [PW-1:0]       phase;
  logic [PW-1:0]       len;
  kind_t               kind_q;
  owner_t              owner_q;
  logic [AW-1:0]       addr_q;
  logic [DW-1:0]       wdata_q;
  logic [ROW_BITS-1:0] row_q;
  logic [DW-1:0]       rd_q;

  logic   ref_pend, at_wait, at_last, hold, can_start, take, take_ref;
  owner_t grant;

  assign at_wait   = busy && (phase == len - 1'b1);
  assign at_last   = busy && (phase == len);
  assign hold      = at_wait && !bus_ready;
  assign can_start = !busy || at_last;
  assign take      = can_start && (grant != O_NONE);
  assign take_ref  = take && (grant == O_REF);

  ebs_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk (clk),
    .rst (rst),
    .take(take_ref),
    .pend(ref_pend)
  );

  ebs_arbiter u_arb (
    .ref_pend(ref_pend),
    .dma_req (dma_req),
    .cpu_req (cpu_req),
    .grant   (grant)
  );

  ebs_nmi_latch u_nmi (
    .clk(clk),
    .rst(rst),
    .chk(chan_chk),
    .ack(nmi_ack),
    .nmi(nmi_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      phase   <= '0;
      len     <= MEM_L;
      kind_q  <= K_MRD;
      owner_q <= O_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
      row_q   <= '0;
      rd_q    <= '0;
    end else begin
      if (at_last) begin
        if (owner_q == O_CPU && !kind_q[0]) rd_q <= bus_din;
        if (owner_q == O_REF) row_q <= row_q + 1'b1;
      end
      if (take) begin
        busy    <= 1'b1;
        phase   <= PW'(1);
        owner_q <= grant;
        case (grant)
          O_REF: begin
            kind_q <= K_MRD;
            addr_q <= {{(AW-ROW_BITS){1'b0}}, row_q};
            len    <= REF_L;
          end
          O_DMA: begin
            kind_q <= kind_t'(dma_kind);
            addr_q <= shape_addr(kind_t'(dma_kind), dma_addr);
            len    <= DMA_L;
          end
          default: begin
            kind_q  <= kind_t'(cpu_kind);
            addr_q  <= shape_addr(kind_t'(cpu_kind), cpu_addr);
            wdata_q <= cpu_wdata;
            len     <= cpu_kind[1] ? IO_L : MEM_L;
          end
        endcase
      end else if (can_start) begin
        busy    <= 1'b0;
        phase   <= '0;
        owner_q <= O_NONE;
      end else if (!hold) begin
        phase <= phase + 1'b1;
      end
    end
  end

  logic strobe_on;
  assign strobe_on   = busy && (phase >= PW'(2));
  assign mem_rd      = strobe_on && (kind_q == K_MRD);
  assign mem_wr      = strobe_on && (kind_q == K_MWR);
  assign io_rd       = strobe_on && (kind_q == K_IORD);
  assign io_wr       = strobe_on && (kind_q == K_IOWR);
  assign bus_doe     = strobe_on && (owner_q == O_CPU) && kind_q[0];
  assign bus_dout    = wdata_q;
  assign bus_addr    = addr_q;
  assign rd_data     = rd_q;
  assign cpu_ack     = busy && (phase == PW'(1)) && (owner_q == O_CPU);
  assign dma_ack     = busy && (phase == PW'(1)) && (owner_q == O_DMA);
  assign refresh_cyc = busy && (owner_q == O_REF);
endmodule

// File: rtl/ebs_sequencer_chk.sv
module ebs_sequencer_chk #(
  parameter int AW      = 20,
  parameter int IO_BITS = 9,
  parameter int PW      = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          io_rd,
  input logic          io_wr,
  input logic [AW-1:0] bus_addr,
  input logic          bus_doe,
  input logic          bus_ready,
  input logic          refresh_cyc,
  input logic          chan_chk,
  input logic          nmi_ack,
  input logic          nmi_req,
  input logic          busy,
  input logic [PW-1:0] phase,
  input logic [PW-1:0] len
);
  logic any_strobe;
  assign any_strobe = mem_rd | mem_wr | io_rd | io_wr;

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

  assert_io_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (io_rd || io_wr) |-> (bus_addr[AW-1:IO_BITS] == '0));

  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (any_strobe && $past(any_strobe)) |-> $stable(bus_addr));

  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && phase == len - 1'b1 && !bus_ready) |=> $stable(phase));

  assert_refresh_rd_R4: assert property (@(posedge clk) disable iff (rst)
    (refresh_cyc && any_strobe) |-> mem_rd);

  assert_doe_write_R9: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> (mem_wr || io_wr));

  assert_nmi_set_R8: assert property (@(posedge clk) disable iff (rst)
    chan_chk |=> nmi_req);

  assert_nmi_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && !nmi_ack) |=> nmi_req);

  assert_nmi_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (nmi_ack && !chan_chk) |=> !nmi_req);
endmodule

bind ebs_sequencer ebs_sequencer_chk #(.AW(AW), .IO_BITS(IO_BITS), .PW(PW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .bus_addr   (bus_addr),
  .bus_doe    (bus_doe),
  .bus_ready  (bus_ready),
  .refresh_cyc(refresh_cyc),
  .chan_chk   (chan_chk),
  .nmi_ack    (nmi_ack),
  .nmi_req    (nmi_req),
  .busy       (busy),
  .phase      (phase),
  .len        (len)
);

// File: tb/ebs_sequencer_test.sv
module ebs_sequencer_test;
  localparam int PER = 72;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, dma_req = 1'b0;
  logic [1:0]  cpu_kind = 2'd0, dma_kind = 2'd0;
  logic [19:0] cpu_addr = '0, dma_addr = '0;
  logic [7:0]  cpu_wdata = '0, bus_din = 8'h3C;
  logic        bus_ready = 1'b1, chan_chk = 1'b0, nmi_ack = 1'b0;
  logic        cpu_ack, dma_ack, mem_rd, mem_wr, io_rd, io_wr, bus_doe, refresh_cyc, nmi_req;
  logic [19:0] bus_addr;
  logic [7:0]  bus_dout, rd_data;

  always #5 clk = ~clk;

  ebs_sequencer uut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
    .dma_req(dma_req), .dma_kind(dma_kind), .dma_addr(dma_addr), .dma_ack(dma_ack),
    .bus_ready(bus_ready), .bus_din(bus_din), .chan_chk(chan_chk), .nmi_ack(nmi_ack),
    .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .rd_data(rd_data),
    .refresh_cyc(refresh_cyc), .nmi_req(nmi_req)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_busy, m_phase, m_len, m_kind, m_owner, m_tick, m_pend, m_row, m_nmi, m_rd;
  int m_wd, pend0, row0, setp, start, took;
  logic [19:0] m_addr;

  function automatic logic [19:0] mshape(int k, logic [19:0] a);
    return (k >= 2) ? {11'd0, a[8:0]} : a;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_phase = 0; m_len = 4; m_kind = 0; m_owner = 0; m_tick = 0;
      m_pend = 0; m_row = 0; m_nmi = 0; m_rd = 0; m_wd = 0; m_addr = '0;
    end else begin
      pend0 = m_pend; row0 = m_row;
      if (m_tick == PER - 1) begin m_tick = 0; setp = 1; end
      else begin m_tick = m_tick + 1; setp = 0; end
      start = 0;
      if (m_busy != 0) begin
        if (m_phase == m_len - 1 && !bus_ready) start = 0;
        else if (m_phase == m_len) begin
          if (m_owner == 1 && (m_kind == 0 || m_kind == 2)) m_rd = bus_din;
          if (m_owner == 3) m_row = (m_row + 1) % 256;
          start = 1;
        end else m_phase = m_phase + 1;
      end else start = 1;
      if (start != 0) begin
        took = 1;
        if (pend0 != 0) begin
          m_owner = 3; m_kind = 0; m_addr = 20'(row0); m_len = 5;
        end else if (dma_req) begin
          m_owner = 2; m_kind = dma_kind; m_addr = mshape(dma_kind, dma_addr); m_len = 5;
        end else if (cpu_req) begin
          m_owner = 1; m_kind = cpu_kind; m_addr = mshape(cpu_kind, cpu_addr);
          m_wd = cpu_wdata; m_len = (cpu_kind >= 2) ? 5 : 4;
        end else took = 0;
        if (took != 0) begin m_busy = 1; m_phase = 1; end
        else begin m_busy = 0; m_phase = 0; m_owner = 0; end
      end
      if (setp != 0) m_pend = 1;
      else if (start != 0 && pend0 != 0) m_pend = 0;
      if (chan_chk) m_nmi = 1;
      else if (nmi_ack) m_nmi = 0;
    end
  end

  // clock-by-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit son;
      son = (m_busy != 0) && (m_phase >= 2);
      chk({mem_rd, mem_wr, io_rd, io_wr} ==
          {son && m_kind == 0, son && m_kind == 1, son && m_kind == 2, son && m_kind == 3},
          "R1", "strobes", {mem_rd, mem_wr, io_rd, io_wr},
          {son && m_kind == 0, son && m_kind == 1, son && m_kind == 2, son && m_kind == 3});
      chk(bus_addr == m_addr, "R2", "address", bus_addr, m_addr);
      chk(refresh_cyc == (m_busy != 0 && m_owner == 3), "R4", "refresh_cyc", refresh_cyc, m_owner == 3);
      chk({cpu_ack, dma_ack} == {m_busy != 0 && m_phase == 1 && m_owner == 1,
                                 m_busy != 0 && m_phase == 1 && m_owner == 2},
          "R6", "acks", {cpu_ack, dma_ack}, {m_phase == 1 && m_owner == 1, m_phase == 1 && m_owner == 2});
      chk(bus_doe == (son && m_owner == 1 && (m_kind == 1 || m_kind == 3)), "R9", "bus_doe", bus_doe, 0);
      if (bus_doe) chk(bus_dout == 8'(m_wd), "R9", "bus_dout", bus_dout, m_wd);
      chk(rd_data == 8'(m_rd), "R9", "rd_data", rd_data, m_rd);
      chk(nmi_req == (m_nmi != 0), "R8", "nmi_req", nmi_req, m_nmi);
    end
  end

  // ---------------- stimulus ----------------
  logic [19:0] addr_seen;
  bit          doe_seen;
  logic [7:0]  dout_seen;

  task automatic run_cycle(input bit use_dma, input logic [1:0] k, input logic [19:0] a,
                           input logic [7:0] d, input int w, output int n);
    int i;
    @(negedge clk);
    if (use_dma) begin dma_req = 1; dma_kind = k; dma_addr = a; end
    else begin cpu_req = 1; cpu_kind = k; cpu_addr = a; cpu_wdata = d; end
    forever begin
      @(negedge clk);
      if (use_dma ? dma_ack : cpu_ack) break;
    end
    cpu_req = 0; dma_req = 0;
    if (w > 0) bus_ready = 0;
    n = 0; i = 0; doe_seen = 0;
    forever begin
      @(negedge clk);
      i++;
      if (i >= w) bus_ready = 1;
      if (mem_rd | mem_wr | io_rd | io_wr) begin
        if (n == 0) begin addr_seen = bus_addr; doe_seen = bus_doe; dout_seen = bus_dout; end
        n++;
      end else if (n > 0) break;
    end
  endtask

  task automatic wait_refresh_start();
    while (refresh_cyc) @(negedge clk);
    while (!refresh_cyc) @(negedge clk);
  endtask

  initial begin
    int n, r0, rc, rd_cnt;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({mem_rd, mem_wr, io_rd, io_wr, cpu_ack, dma_ack, bus_doe, refresh_cyc, nmi_req} == 0,
        "R10", "reset outputs", {mem_rd, mem_wr, io_rd, io_wr, cpu_ack, dma_ack, bus_doe, refresh_cyc, nmi_req}, 0);
    chk(rd_data == 0, "R10", "reset rd_data", rd_data, 0);
    rst = 0;

    // R1 memory read, R9 capture
    bus_din = 8'h3C;
    run_cycle(0, 2'd0, 20'hABCDE, 8'h00, 0, n);
    chk(n == 3, "R1", "mem read strobe clocks", n, 3);
    chk(addr_seen == 20'hABCDE, "R1", "mem address", addr_seen, 20'hABCDE);
    chk(rd_data == 8'h3C, "R9", "read capture", rd_data, 8'h3C);

    // R1 memory write, R9 drive
    run_cycle(0, 2'd1, 20'h54321, 8'h5A, 0, n);
    chk(n == 3, "R1", "mem write strobe clocks", n, 3);
    chk(doe_seen && dout_seen == 8'h5A, "R9", "write data driven", dout_seen, 8'h5A);

    // R2 I/O read and write
    bus_din = 8'hC3;
    run_cycle(0, 2'd2, 20'hFFFFF, 8'h00, 0, n);
    chk(n == 4, "R2", "io read strobe clocks", n, 4);
    chk(addr_seen == 20'h001FF, "R2", "io address masked", addr_seen, 20'h001FF);
    chk(rd_data == 8'hC3, "R9", "io read capture", rd_data, 8'hC3);
    run_cycle(0, 2'd3, 20'h00E07, 8'h81, 0, n);
    chk(n == 4, "R2", "io write strobe clocks", n, 4);
    chk(addr_seen == 20'h00007, "R2", "io write address", addr_seen, 20'h00007);

    // R3 DMA
    run_cycle(1, 2'd1, 20'h12345, 8'h00, 0, n);
    chk(n == 4, "R3", "dma strobe clocks", n, 4);
    chk(addr_seen == 20'h12345, "R3", "dma address", addr_seen, 20'h12345);
    chk(!doe_seen, "R9", "dma does not drive data", doe_seen, 0);

    // R5 wait states
    run_cycle(0, 2'd0, 20'h00100, 8'h00, 5, n);
    chk(n == 6, "R5", "mem cycle stretched", n, 6);
    run_cycle(0, 2'd2, 20'h00100, 8'h00, 6, n);
    chk(n == 7, "R5", "io cycle stretched", n, 7);

    // R4 refresh cycles
    wait_refresh_start();
    r0 = bus_addr[7:0];
    chk(bus_addr[19:8] == 0, "R4", "refresh upper address", bus_addr[19:8], 0);
    rc = 0; rd_cnt = 0;
    while (refresh_cyc) begin
      rc++;
      if (mem_rd) rd_cnt++;
      @(negedge clk);
    end
    chk(rc == 5, "R4", "refresh length", rc, 5);
    chk(rd_cnt == 4, "R4", "refresh mem_rd clocks", rd_cnt, 4);
    wait_refresh_start();
    chk(bus_addr[7:0] == 8'((r0 + 1) % 256), "R4", "row advance", bus_addr[7:0], (r0 + 1) % 256);

    // R6 refresh held behind a long cycle
    run_cycle(0, 2'd2, 20'h00020, 8'h00, 80, n);
    chk(n == 81, "R5", "long stretch", n, 81);
    chk(refresh_cyc, "R6", "pending refresh follows at once", refresh_cyc, 1);

    // R6 priority: dma over cpu
    wait_refresh_start();
    @(negedge clk);
    dma_req = 1; dma_kind = 2'd0; dma_addr = 20'h0AAAA;
    cpu_req = 1; cpu_kind = 2'd0; cpu_addr = 20'h05555;
    while (!(dma_ack || cpu_ack)) @(negedge clk);
    chk(dma_ack && !cpu_ack, "R6", "dma wins over cpu", {dma_ack, cpu_ack}, 2'b10);
    dma_req = 0;
    while (!cpu_ack) @(negedge clk);
    cpu_req = 0;
    repeat (8) @(negedge clk);

    // R8 interrupt latch
    chan_chk = 1;
    @(negedge clk); chan_chk = 0;
    chk(nmi_req, "R8", "nmi set", nmi_req, 1);
    repeat (3) @(negedge clk);
    chk(nmi_req, "R8", "nmi held", nmi_req, 1);
    chan_chk = 1; nmi_ack = 1;
    @(negedge clk); chan_chk = 0; nmi_ack = 0;
    chk(nmi_req, "R8", "set beats ack", nmi_req, 1);
    nmi_ack = 1;
    @(negedge clk); nmi_ack = 0;
    chk(!nmi_req, "R8", "nmi cleared", nmi_req, 0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule